// File: doc/BRIEF.md
# Configurable-Ratio Transmit Serializer

This block turns a parallel word into a serial bit stream for a differential transmit lane. The word is as wide as the chosen serialization factor and is sent least-significant bit first. The legal factors are 2 to 8 and 10. A factor of 1 turns the block into a plain registered buffer.

In full-rate operation one bit leaves per serial clock. In half-rate operation two bits leave per serial clock, as a pair: the rising-edge bit and then the falling-edge bit. A clock-forwarding mode ignores the data and sends a repeating clock pattern with the same frame length as the data lanes. An output enable gates the data lane. A configuration-error flag reports factor and rate combinations that cannot be used.

The block runs entirely on the serial clock. The parallel clock comes from the same source at a fixed ratio. The parallel side must therefore hold each word stable until the serializer takes it. The block marks this moment with a frame strobe.

Top module: `tx_serializer`

## Requirements
- R1: `cfg_factor` values 0, 9 and anything above 10 raise `cfg_err_o`. The flag follows the configuration inputs in the same cycle. While it is high, `ser_o` is 2'b00, `oe_o` is 0 and `frame_o` stays low.
- R2: With factor 1 and full rate, each clock edge puts `par_data[0]` on both bits of `ser_o`, one cycle after it was sampled.
- R3: In full rate, a frame lasts `cfg_factor` cycles. In slot k of the frame, both `ser_o[0]` and `ser_o[1]` carry bit k of the captured word.
- R4: In half rate, a frame lasts `cfg_factor`/2 cycles. In slot k of the frame, `ser_o[0]` (rising-edge bit) carries word bit 2k and `ser_o[1]` (falling-edge bit) carries bit 2k+1.
- R5: Half rate with an odd factor, including factor 1, raises `cfg_err_o` and idles the outputs as in R1.
- R6: `par_data` bits at or above position `cfg_factor` never appear on `ser_o`.
- R7: The word is captured only on the edge that ends a cycle in which `frame_o` is 1, which is slot 0 of each frame. Changes to `par_data` during the other slots have no effect on the frame in progress.
- R8: With `cfg_clk_fwd` = 1, the data input is ignored and each frame carries a pattern of ones in bit positions below ceil(factor/2) and zeros above. This pattern is emitted in the order of R3 or R4. `oe_o` is 1 whatever `oe_i` is.
- R9: In data mode, `oe_i` sampled low on an edge makes `oe_o` 0 and `ser_o` 2'b00 for that slot. Framing continues unchanged, so later slots still carry the bits they are due.
- R10: While `rst_n` is low, `ser_o` is 2'b00 and `oe_o` is 0. The first cycle after release is slot 0, with `frame_o` high when the configuration is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ser | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_factor | input | 4 | Serialization factor |
| cfg_half | input | 1 | 1 = half rate (two bits per clock) |
| cfg_clk_fwd | input | 1 | 1 = forwarded-clock pattern instead of data |
| par_data | input | 10 | Parallel word, LSB sent first |
| oe_i | input | 1 | Output enable request (data mode) |
| frame_o | output | 1 | High in the cycle whose closing edge captures a word |
| ser_o | output | 2 | [0] rising-edge bit, [1] falling-edge bit |
| oe_o | output | 1 | Enable towards the pad |
| cfg_err_o | output | 1 | Illegal factor or rate combination |

## Verification
Random words across every legal factor at both rates separate bit ordering, pair ordering and frame length. A wrong slot count or a swapped pair shows up as a mismatch within one frame. Random data written into the non-capture slots and random upper bits above the factor separate true frame-start capture and masking from a design that samples data continuously. Random output-enable gaps show that gating blanks a single slot without slipping the frame. Forwarded-clock runs at odd and even factors, together with the factors 0, 9, 11 and odd half-rate factors, cover the pattern rounding and every error path.

// File: rtl/tx_ser_pkg.sv
package tx_ser_pkg;

    // Factor that has no hardware support and is rejected by the decoder
    localparam int unsigned TX_SKIPPED_FACTOR = 9;
    localparam int unsigned TX_DEF_MAX_FACTOR = 10;

    // Legality of a serialization factor against the supported maximum
    function automatic logic factor_ok(input logic [7:0] f, input int unsigned maxf);
        logic ok;
        ok = (f != 8'd0) && (int'(f) <= int'(maxf)) && (int'(f) != int'(TX_SKIPPED_FACTOR));
        return ok;
    endfunction

endpackage

// File: rtl/tx_ser_cfg.sv
module tx_ser_cfg
    import tx_ser_pkg::*;
#(
    parameter int unsigned MAX_FACTOR = TX_DEF_MAX_FACTOR,
    parameter int unsigned CW         = $clog2(MAX_FACTOR + 1)
) (
    input  logic [CW-1:0] factor,
    input  logic          half,
    output logic          err,
    output logic [CW-1:0] slots
);
    logic legal_factor;
    logic odd_half;

    always_comb begin
        legal_factor = factor_ok(8'(factor), MAX_FACTOR);
        odd_half     = half && factor[0];
        err          = !legal_factor || odd_half;
        // number of serial cycles per frame
        slots        = half ? (factor >> 1) : factor;
        if (err) slots = CW'(1);
    end
endmodule

// File: rtl/tx_ser_frame_ctr.sv
module tx_ser_frame_ctr #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] slots,
    output logic          take
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_t;

    ctr_t q, d;
    logic [CW:0] cnt_inc;

    always_comb begin
        d       = q;
        cnt_inc = {1'b0, q.cnt} + (CW+1)'(1);
        if (!run) begin
            d.cnt = '0;
        end else if (cnt_inc >= {1'b0, slots}) begin
            d.cnt = '0;
        end else begin
            d.cnt = cnt_inc[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign take = run && (q.cnt == '0);

    // R7
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (q.cnt == slots - CW'(1))) |=> (q.cnt == '0));

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (q.cnt < slots));
endmodule

// File: rtl/tx_ser_shift.sv
module tx_ser_shift #(
    parameter int unsigned MAX_FACTOR = 10,
    parameter int unsigned CW         = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take,
    input  logic                  err,
    input  logic                  half,
    input  logic                  clk_fwd,
    input  logic [CW-1:0]         factor,
    input  logic [MAX_FACTOR-1:0] data,
    input  logic                  oe_in,
    output logic [1:0]            ser,
    output logic                  oe_out
);
    localparam int unsigned HW = CW + 1;

    logic [HW-1:0]         ones_len;
    logic [MAX_FACTOR-1:0] masked;
    logic [MAX_FACTOR-1:0] pattern;

    assign ones_len = (HW'(factor) + HW'(1)) >> 1;

    for (genvar i = 0; i < MAX_FACTOR; i++) begin : g_bit
        assign masked[i]  = data[i] & (HW'(i) < HW'(factor));
        assign pattern[i] = (HW'(i) < ones_len);
    end

    typedef struct packed {
        logic [MAX_FACTOR-1:0] sh;
        logic [1:0]            pair;
        logic                  oe;
    } shf_t;

    shf_t q, d;
    logic [MAX_FACTOR-1:0] src;
    logic [1:0]            nxt;
    logic                  blank;

    always_comb begin
        d   = q;
        src = take ? (clk_fwd ? pattern : masked) : q.sh;
        if (half) begin
            nxt  = src[1:0];
            d.sh = src >> 2;
        end else begin
            nxt  = {src[0], src[0]};
            d.sh = src >> 1;
        end
        if (err) d.sh = '0;
        blank  = err || (!clk_fwd && !oe_in);
        d.pair = blank ? 2'b00 : nxt;
        d.oe   = !err && (clk_fwd || oe_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ser    = q.pair;
    assign oe_out = q.oe;
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
    import tx_ser_pkg::*;
#(
    parameter int unsigned MAX_FACTOR = TX_DEF_MAX_FACTOR,
    localparam int unsigned CW        = $clog2(MAX_FACTOR + 1)
) (
    input  logic                  clk_ser,
    input  logic                  rst_n,
    input  logic [CW-1:0]         cfg_factor,
    input  logic                  cfg_half,
    input  logic                  cfg_clk_fwd,
    input  logic [MAX_FACTOR-1:0] par_data,
    input  logic                  oe_i,
    output logic                  frame_o,
    output logic [1:0]            ser_o,
    output logic                  oe_o,
    output logic                  cfg_err_o
);
    logic          err;
    logic [CW-1:0] slots;
    logic          take;

    tx_ser_cfg #(.MAX_FACTOR(MAX_FACTOR), .CW(CW)) u_cfg (
        .factor (cfg_factor),
        .half   (cfg_half),
        .err    (err),
        .slots  (slots)
    );

    tx_ser_frame_ctr #(.CW(CW)) u_ctr (
        .clk   (clk_ser),
        .rst_n (rst_n),
        .run   (!err),
        .slots (slots),
        .take  (take)
    );

    tx_ser_shift #(.MAX_FACTOR(MAX_FACTOR), .CW(CW)) u_shf (
        .clk     (clk_ser),
        .rst_n   (rst_n),
        .take    (take),
        .err     (err),
        .half    (cfg_half),
        .clk_fwd (cfg_clk_fwd),
        .factor  (cfg_factor),
        .data    (par_data),
        .oe_in   (oe_i),
        .ser     (ser_o),
        .oe_out  (oe_o)
    );

    assign frame_o   = take;
    assign cfg_err_o = err;

    // R1
    err_idle_chk: assert property (@(posedge clk_ser) disable iff (!rst_n)
        cfg_err_o |=> (ser_o == 2'b00 && !oe_o));

    // R3
    full_pair_chk: assert property (@(posedge clk_ser) disable iff (!rst_n)
        (!cfg_half && !cfg_err_o) |-> (ser_o[0] == ser_o[1]));

    // R9
    oe_gate_chk: assert property (@(posedge clk_ser) disable iff (!rst_n)
        (!cfg_clk_fwd && !oe_i && !cfg_err_o) |=> (ser_o == 2'b00 && !oe_o));

    // R8
    fwd_lead_chk: assert property (@(posedge clk_ser) disable iff (!rst_n)
        (cfg_clk_fwd && frame_o) |=> (ser_o[0] && oe_o));
endmodule

// File: tb/sim_tx_serializer.sv
`timescale 1ns/1ps
module sim_tx_serializer;
    logic       clk_ser = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg_factor = 4'd2;
    logic       cfg_half = 1'b0;
    logic       cfg_clk_fwd = 1'b0;
    logic [9:0] par_data = '0;
    logic       oe_i = 1'b0;
    logic       frame_o;
    logic [1:0] ser_o;
    logic       oe_o;
    logic       cfg_err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk_ser = ~clk_ser;

    tx_serializer u0 (
        .clk_ser(clk_ser), .rst_n(rst_n), .cfg_factor(cfg_factor), .cfg_half(cfg_half),
        .cfg_clk_fwd(cfg_clk_fwd), .par_data(par_data), .oe_i(oe_i),
        .frame_o(frame_o), .ser_o(ser_o), .oe_o(oe_o), .cfg_err_o(cfg_err_o)
    );

    task automatic chk(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_pair(input logic [9:0] w, input int f, input bit half,
                                            input bit fwd, input int k);
        logic [9:0] src;
        for (int i = 0; i < 10; i++) src[i] = fwd ? (i < (f + 1) / 2) : (i < f ? w[i] : 1'b0);
        if (half) return {src[2*k+1], src[2*k]};
        return {src[k], src[k]};
    endfunction

    task automatic do_reset(input int f, input bit half, input bit fwd);
        @(negedge clk_ser);
        rst_n = 1'b0;
        cfg_factor = 4'(f); cfg_half = half; cfg_clk_fwd = fwd;
        oe_i = 1'b1; par_data = 10'($urandom);
        repeat (2) @(negedge clk_ser);
        chk("R10", "ser in reset", {2'b0, ser_o}, 4'h0);
        chk("R10", "oe in reset", {3'b0, oe_o}, 4'h0);
        rst_n = 1'b1;
    endtask

    // Sits at a negedge on entry and exit; each iteration covers one slot
    task automatic run_cfg(input int f, input bit half, input bit fwd, input int nframes,
                           input bit use_fixed, input logic [9:0] fixed_w);
        int slots;
        logic [9:0] w;
        bit oe_cur;
        slots = half ? f / 2 : f;
        do_reset(f, half, fwd);
        chk("R10", "frame_o after release", {3'b0, frame_o}, 4'h1);
        chk("R1", "no error on legal cfg", {3'b0, cfg_err_o}, 4'h0);
        for (int fr = 0; fr < nframes; fr++) begin
            w = use_fixed ? fixed_w : 10'($urandom);
            for (int k = 0; k < slots; k++) begin
                // R7: only slot 0 data counts, garbage elsewhere
                par_data = (k == 0) ? w : 10'($urandom);
                oe_cur = ($urandom % 5) != 0;
                oe_i = oe_cur;
                chk("R7", "frame_o slot", {3'b0, frame_o}, {3'b0, k == 0});
                @(posedge clk_ser);
                @(negedge clk_ser);
                if (fwd)
                    chk("R8", "fwd pattern", {2'b0, ser_o}, {2'b0, exp_pair(w, f, half, 1'b1, k)});
                else if (!oe_cur)
                    chk("R9", "gated slot", {2'b0, ser_o}, 4'h0);
                else if (f == 1)
                    chk("R2", "bypass", {2'b0, ser_o}, {2'b0, w[0], w[0]});
                else if (half)
                    chk("R4", "half pair", {2'b0, ser_o}, {2'b0, exp_pair(w, f, 1'b1, 1'b0, k)});
                else
                    chk("R3", "full bit", {2'b0, ser_o}, {2'b0, exp_pair(w, f, 1'b0, 1'b0, k)});
                chk("R9", "oe_o", {3'b0, oe_o}, {3'b0, fwd ? 1'b1 : oe_cur});
            end
        end
    endtask

    task automatic run_err(input int f, input bit half, input string tag);
        do_reset(f, half, 1'b0);
        for (int c = 0; c < 6; c++) begin
            par_data = 10'($urandom);
            oe_i = 1'b1;
            @(posedge clk_ser);
            @(negedge clk_ser);
            chk(tag, "err flag", {3'b0, cfg_err_o}, 4'h1);
            chk(tag, "idle ser", {2'b0, ser_o}, 4'h0);
            chk(tag, "idle oe", {3'b0, oe_o}, 4'h0);
            chk(tag, "no frame", {3'b0, frame_o}, 4'h0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        int fl[9];
        fl = '{2, 3, 4, 5, 6, 7, 8, 10, 1};
        void'($urandom(32'h5EED));
        // R3, R6: every legal factor at full rate
        foreach (fl[i]) run_cfg(fl[i], 1'b0, 1'b0, 6, 1'b0, '0);
        // R4: even factors at half rate
        for (int f = 2; f <= 10; f += 2) run_cfg(f, 1'b1, 1'b0, 6, 1'b0, '0);
        // R6: directed: upper bits all ones must not leak
        run_cfg(3, 1'b0, 1'b0, 3, 1'b1, 10'h3F8);
        run_cfg(10, 1'b0, 1'b0, 2, 1'b1, 10'h2AA);
        // R8: forwarded clock, odd and even factors
        run_cfg(3, 1'b0, 1'b1, 3, 1'b0, '0);
        run_cfg(7, 1'b0, 1'b1, 3, 1'b0, '0);
        run_cfg(10, 1'b0, 1'b1, 3, 1'b0, '0);
        run_cfg(6, 1'b1, 1'b1, 3, 1'b0, '0);
        // R1, R5: illegal configurations
        run_err(9, 1'b0, "R1");
        run_err(0, 1'b0, "R1");
        run_err(11, 1'b0, "R1");
        run_err(5, 1'b1, "R5");
        run_err(1, 1'b1, "R5");
        finish_run();
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk_ser);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule